// File: doc/BRIEF.md
# Coherent Snooping Bus Hub with Memory Responder

This block is the shared interconnect for a group of write-back caches that keep a line coherent by watching one another's traffic. Each cache raises a request carrying a kind (shared read, read-for-ownership, upgrade or eviction writeback), a line address and, for writebacks, the line data. A fixed-priority arbiter admits one request at a time. For the three coherence kinds, the hub puts the request on a broadcast snoop channel that every cache watches. Each of the other caches answers once, saying whether it keeps a copy, whether it is flushing the line and whether that flushed line was dirty.

The hub gathers the answers, which may arrive over several cycles. Once every non-requesting cache has answered, it decides where the data comes from. A flushing cache wins over memory. A dirty flush is also written into the on-chip memory array in the same cycle the hub takes it. When no cache flushes, the memory model returns the line after a fixed latency. An upgrade only needs an acknowledge. A writeback is never snooped and goes straight into memory.

Only one transaction is in flight. The grant stays asserted until a one-cycle response pulse, which carries the line and the combined "someone else shares it" flag back to the requester.

Top module: `coh_bus_hub`

## Requirements
- R1: When the hub is idle and several caches request, the lowest-indexed requester receives the grant on the next clock edge, and at most one grant bit is ever set.
- R2: A grant stays unchanged until the cycle after the one-cycle `rspValid` pulse, when it drops to zero; a waiting requester can be granted on the very next edge.
- R3: For request kinds 0 (shared read), 1 (read-for-ownership) and 2 (upgrade), `snoopValid` is high with the kind, address and requester index from the cycle after the grant edge until the edge on which every non-requesting cache has pulsed `snpDone`. All response inputs from the requester itself are ignored.
- R4: `rspShared` equals the OR of `snpShared` over the non-requesting caches, each taken in the cycle of its `snpDone`.
- R5: If any non-requesting cache asserts `snpFlush` with its `snpDone`, `rspValid` rises in the cycle after the last answer. `rspData` is the `snpData` of the lowest-indexed flushing cache, even when flushes arrive in different cycles.
- R6: If no cache flushes a read, the data comes from the memory array at index `addr[MIDX_W-1:0]`. `rspValid` rises `RD_LAT` cycles later than it would in the flush case.
- R7: If a selected read flush comes with `snpDirty` from any flushing cache, the memory line is overwritten with the selected flush data on that same edge, and later reads return it. A clean flush leaves memory unchanged.
- R8: An upgrade (kind 2) is acknowledged in the cycle after the last answer, with `rspShared` valid and no memory access.
- R9: A writeback (kind 3) is never snooped. The memory line is written on the grant edge, and `rspValid` echoes the written data in the following cycle.
- R10: After reset, grant, `snoopValid` and `rspValid` are low and every memory line reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | N | Per-cache request strobe, held until granted |
| reqKind | input | N x 2 | Per-cache request kind (0 read, 1 read-own, 2 upgrade, 3 writeback) |
| reqAddr | input | N x ADDR_W | Per-cache line address |
| reqData | input | N x LINE_W | Per-cache writeback data |
| grant | output | N | One-hot grant to the cache that owns the transaction |
| snoopValid | output | 1 | Broadcast snoop is active |
| snoopKind | output | 2 | Kind of the snooped request |
| snoopAddr | output | ADDR_W | Address of the snooped request |
| snoopSrc | output | IDX_W | Index of the requesting cache |
| snpDone | input | N | Per-cache one-shot answer strobe |
| snpShared | input | N | Cache keeps a copy |
| snpFlush | input | N | Cache drives the line on snpData |
| snpDirty | input | N | Flushed line was modified |
| snpData | input | N x LINE_W | Per-cache flushed line |
| rspValid | output | 1 | One-cycle response to the granted cache |
| rspShared | output | 1 | Another cache keeps a copy |
| rspData | output | LINE_W | Returned line |

## Verification
The hardest case to reach from the ports is a flush selection that changes over time. A higher-indexed cache flushes first, and a lower-indexed one flushes in a later cycle, so the hub must replace its chosen line before it decides. The bench builds this case by holding back the lowest-indexed non-requester's answer by one cycle while other caches flush early, each with a different line. A later memory read then shows whether the dirty line that was written back was the selected one. The requester also drives junk answers with every bit set, so any leak of its own response shows up in the shared flag or the data.

// File: rtl/coh_bus_pkg.sv
package coh_bus_pkg;

  typedef enum logic [1:0] {
    KIND_RD   = 2'd0,
    KIND_RDX  = 2'd1,
    KIND_UPGR = 2'd2,
    KIND_WB   = 2'd3
  } busKind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SNOOP = 2'd1,
    ST_MEMRD = 2'd2,
    ST_RESP  = 2'd3
  } busState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic takeReq;     // latch the winning request
    logic writeWb;     // winning request is a writeback: store it now
    logic collect;     // snoop answers are being gathered
    logic finishSnoop; // last answer arrives this cycle
    logic loadMem;     // memory read latency expires
  } busStrobe_t;

endpackage

// File: rtl/coh_bus_ctrl.sv
module coh_bus_ctrl
  import coh_bus_pkg::*;
#(
  parameter int N      = 4,
  parameter int RD_LAT = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(RD_LAT + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N-1:0]          reqValid,
  input  logic [N-1:0][1:0]     reqKind,
  input  logic [1:0]            curKind,
  input  logic                  allDone,
  input  logic                  anyFlush,
  output logic [N-1:0]          grant,
  output logic [IDX_W-1:0]      winIdx,
  output busStrobe_t            strobe,
  output logic                  snoopActive,
  output logic                  rspActive
);

  busState_e        state;
  logic [CNT_W-1:0] latCnt;
  logic             anyReq;

  // fixed priority: scanning downward leaves the lowest requester
  always_comb begin
    winIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (reqValid[i]) winIdx = IDX_W'(i);
    end
    anyReq = |reqValid;
  end

  always_comb begin
    strobe.takeReq     = (state == ST_IDLE) && anyReq;
    strobe.writeWb     = strobe.takeReq && (reqKind[winIdx] == KIND_WB);
    strobe.collect     = (state == ST_SNOOP);
    strobe.finishSnoop = strobe.collect && allDone;
    strobe.loadMem     = (state == ST_MEMRD) && (latCnt == CNT_W'(1));
  end

  assign snoopActive = (state == ST_SNOOP);
  assign rspActive   = (state == ST_RESP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      grant  <= '0;
      latCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (anyReq) begin
            grant <= N'(1) << winIdx;
            state <= strobe.writeWb ? ST_RESP : ST_SNOOP;
          end
        end
        ST_SNOOP: begin
          if (allDone) begin
            if ((curKind == KIND_UPGR) || anyFlush) begin
              state <= ST_RESP;
            end else begin
              state  <= ST_MEMRD;
              latCnt <= CNT_W'(RD_LAT);
            end
          end
        end
        ST_MEMRD: begin
          if (latCnt == CNT_W'(1)) state <= ST_RESP;
          else                     latCnt <= latCnt - CNT_W'(1);
        end
        ST_RESP: begin
          state <= ST_IDLE;
          grant <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/coh_bus_dpath.sv
module coh_bus_dpath
  import coh_bus_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 8,
  parameter int LINE_W = 32,
  parameter int MIDX_W = 4,
  localparam int IDX_W     = (N > 1) ? $clog2(N) : 1,
  localparam int MEM_LINES = 1 << MIDX_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  busStrobe_t                 strobe,
  input  logic [IDX_W-1:0]           winIdx,
  input  logic [N-1:0][1:0]          reqKind,
  input  logic [N-1:0][ADDR_W-1:0]   reqAddr,
  input  logic [N-1:0][LINE_W-1:0]   reqData,
  input  logic [N-1:0]               snpDone,
  input  logic [N-1:0]               snpShared,
  input  logic [N-1:0]               snpFlush,
  input  logic [N-1:0]               snpDirty,
  input  logic [N-1:0][LINE_W-1:0]   snpData,
  output logic [IDX_W-1:0]           curIdx,
  output logic [1:0]                 curKind,
  output logic [ADDR_W-1:0]          curAddr,
  output logic                       allDone,
  output logic                       anyFlush,
  output logic                       rspShared,
  output logic [LINE_W-1:0]          rspData
);

  logic [LINE_W-1:0] memArr [MEM_LINES];

  logic [N-1:0]      doneAcc;
  logic              sharedAcc, flushSeen, dirtyAcc;
  logic [IDX_W-1:0]  selIdx, selIdxNext, newIdx;
  logic [LINE_W-1:0] selData, selDataNext;

  logic [N-1:0] fresh, shNow, flNow, dyNow;
  logic         sharedNext, dirtyNext;
  logic [MIDX_W-1:0] memIdx;

  assign memIdx = curAddr[MIDX_W-1:0];

  // per-cache answer qualification; requester bit is preset in doneAcc
  for (genvar g = 0; g < N; g++) begin : g_ans
    assign fresh[g] = strobe.collect && snpDone[g] && !doneAcc[g];
    assign shNow[g] = fresh[g] && snpShared[g];
    assign flNow[g] = fresh[g] && snpFlush[g];
    assign dyNow[g] = flNow[g] && snpDirty[g];
  end

  assign allDone    = &(doneAcc | fresh);
  assign sharedNext = sharedAcc | (|shNow);
  assign anyFlush   = flushSeen | (|flNow);
  assign dirtyNext  = dirtyAcc | (|dyNow);

  // keep a single candidate line: the lowest flushing index seen so far
  always_comb begin
    newIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flNow[i]) newIdx = IDX_W'(i);
    end
    selIdxNext  = selIdx;
    selDataNext = selData;
    if ((|flNow) && (!flushSeen || (newIdx < selIdx))) begin
      selIdxNext  = newIdx;
      selDataNext = snpData[newIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx    <= '0;
      curKind   <= KIND_RD;
      curAddr   <= '0;
      doneAcc   <= '0;
      sharedAcc <= 1'b0;
      flushSeen <= 1'b0;
      dirtyAcc  <= 1'b0;
      selIdx    <= '0;
      selData   <= '0;
      rspShared <= 1'b0;
      rspData   <= '0;
      for (int m = 0; m < MEM_LINES; m++) memArr[m] <= '0;
    end else begin
      if (strobe.takeReq) begin
        curIdx    <= winIdx;
        curKind   <= reqKind[winIdx];
        curAddr   <= reqAddr[winIdx];
        doneAcc   <= N'(1) << winIdx;
        sharedAcc <= 1'b0;
        flushSeen <= 1'b0;
        dirtyAcc  <= 1'b0;
        selIdx    <= '0;
        selData   <= '0;
        rspShared <= 1'b0;
      end
      if (strobe.writeWb) begin
        memArr[reqAddr[winIdx][MIDX_W-1:0]] <= reqData[winIdx];
        rspData <= reqData[winIdx];
      end
      if (strobe.collect) begin
        doneAcc   <= doneAcc | fresh;
        sharedAcc <= sharedNext;
        flushSeen <= anyFlush;
        dirtyAcc  <= dirtyNext;
        selIdx    <= selIdxNext;
        selData   <= selDataNext;
      end
      if (strobe.finishSnoop) begin
        rspShared <= sharedNext;
        if (anyFlush && (curKind != KIND_UPGR)) begin
          rspData <= selDataNext;
          if (dirtyNext) memArr[memIdx] <= selDataNext;
        end
      end
      if (strobe.loadMem) rspData <= memArr[memIdx];
    end
  end

endmodule

// File: rtl/coh_bus_hub.sv
module coh_bus_hub
  import coh_bus_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 8,
  parameter int LINE_W = 32,
  parameter int MIDX_W = 4,
  parameter int RD_LAT = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [N-1:0]             reqValid,
  input  logic [N-1:0][1:0]        reqKind,
  input  logic [N-1:0][ADDR_W-1:0] reqAddr,
  input  logic [N-1:0][LINE_W-1:0] reqData,
  output logic [N-1:0]             grant,
  output logic                     snoopValid,
  output logic [1:0]               snoopKind,
  output logic [ADDR_W-1:0]        snoopAddr,
  output logic [IDX_W-1:0]         snoopSrc,
  input  logic [N-1:0]             snpDone,
  input  logic [N-1:0]             snpShared,
  input  logic [N-1:0]             snpFlush,
  input  logic [N-1:0]             snpDirty,
  input  logic [N-1:0][LINE_W-1:0] snpData,
  output logic                     rspValid,
  output logic                     rspShared,
  output logic [LINE_W-1:0]        rspData
);

  busStrobe_t       strobe;
  logic [IDX_W-1:0] winIdx;
  logic [1:0]       curKind;
  logic             allDone, anyFlush;

  coh_bus_ctrl #(.N(N), .RD_LAT(RD_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .curKind(curKind), .allDone(allDone), .anyFlush(anyFlush),
    .grant(grant), .winIdx(winIdx), .strobe(strobe),
    .snoopActive(snoopValid), .rspActive(rspValid)
  );

  coh_bus_dpath #(.N(N), .ADDR_W(ADDR_W), .LINE_W(LINE_W), .MIDX_W(MIDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .winIdx(winIdx),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqData(reqData),
    .snpDone(snpDone), .snpShared(snpShared), .snpFlush(snpFlush),
    .snpDirty(snpDirty), .snpData(snpData),
    .curIdx(snoopSrc), .curKind(curKind), .curAddr(snoopAddr),
    .allDone(allDone), .anyFlush(anyFlush),
    .rspShared(rspShared), .rspData(rspData)
  );

  assign snoopKind = curKind;

endmodule

// File: rtl/coh_bus_hub_chk.sv
module coh_bus_hub_chk #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [N-1:0]     reqValid,
  input logic [N-1:0]     grant,
  input logic             snoopValid,
  input logic [1:0]       snoopKind,
  input logic [IDX_W-1:0] snoopSrc,
  input logic             rspValid
);

  logic [N-1:0] lowReq;
  assign lowReq = reqValid & (~reqValid + N'(1));

  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_lowest_wins_r1: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0 && reqValid != '0) |=> (grant == $past(lowReq)));

  p_grant_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0 && !rspValid) |=> (grant == $past(grant)));

  p_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (grant == '0 && !rspValid));

  p_snoop_owner_r3: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid |-> (grant[snoopSrc] && snoopKind != 2'd3));

  p_snoop_not_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(snoopValid && rspValid));

  p_rsp_has_owner_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (grant != '0));

endmodule

bind coh_bus_hub coh_bus_hub_chk #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .grant(grant),
  .snoopValid(snoopValid), .snoopKind(snoopKind), .snoopSrc(snoopSrc),
  .rspValid(rspValid)
);

// File: tb/sim_coh_bus_hub.sv
`timescale 1ns/1ps
module sim_coh_bus_hub;

  localparam int N = 4, AW = 8, LW = 32, MW = 4, RD_LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]         reqValid = '0;
  logic [N-1:0][1:0]    reqKind  = '0;
  logic [N-1:0][AW-1:0] reqAddr  = '0;
  logic [N-1:0][LW-1:0] reqData  = '0;
  logic [N-1:0]         grant;
  logic                 snoopValid;
  logic [1:0]           snoopKind;
  logic [AW-1:0]        snoopAddr;
  logic [1:0]           snoopSrc;
  logic [N-1:0]         snpDone = '0, snpShared = '0, snpFlush = '0, snpDirty = '0;
  logic [N-1:0][LW-1:0] snpData = '0;
  logic                 rspValid, rspShared;
  logic [LW-1:0]        rspData;

  coh_bus_hub #(.N(N), .ADDR_W(AW), .LINE_W(LW), .MIDX_W(MW), .RD_LAT(RD_LAT)) u0 (.*);

  // reference model state
  logic [LW-1:0] modelMem [16];
  logic [N-1:0]  expGrant = '0;
  logic          expSnoop = 1'b0, expRsp = 1'b0, expShared = 1'b0, chkData = 1'b0;
  logic [1:0]    expKind = '0;
  logic [AW-1:0] expAddr = '0;
  logic [1:0]    expSrc = '0;
  logic [LW-1:0] expData = '0;
  string         curTag = "R10";
  int nChecks = 0, nErr = 0;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] flushVal(input int i, input logic [AW-1:0] a);
    return 32'hC0DE0000 + (i << 8) + a;
  endfunction

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    check({curTag, " R2 grant"}, grant, expGrant);
    check({curTag, " R3 snoopValid"}, snoopValid, expSnoop);
    check({curTag, " rspValid"}, rspValid, expRsp);
    if (expSnoop) begin
      check("R3 snoopKind", snoopKind, expKind);
      check("R3 snoopAddr", snoopAddr, expAddr);
      check("R3 snoopSrc", snoopSrc, expSrc);
    end
    if (expRsp) check({curTag, " R4 rspShared"}, rspShared, expShared);
    if (expRsp && chkData) check({curTag, " rspData"}, rspData, expData);
  end

  task automatic clearAns();
    snpDone = '0; snpShared = '0; snpFlush = '0; snpDirty = '0; snpData = '0;
  endtask

  task automatic runTxn(input int src, input logic [1:0] kind, input logic [AW-1:0] addr,
                        input logic [LW-1:0] wdata, input logic [3:0] shM,
                        input logic [3:0] flM, input logic [3:0] dyM, input bit stagger);
    logic [3:0] others, fl;
    int late, sel;
    others = 4'hF & ~(4'b1 << src);
    reqValid[src] = 1'b1; reqKind[src] = kind; reqAddr[src] = addr; reqData[src] = wdata;
    @(posedge clk); #1;
    reqValid[src] = 1'b0;
    expGrant = 4'b1 << src;
    if (kind == 2'd3) begin
      modelMem[addr[3:0]] = wdata;
      expRsp = 1'b1; expData = wdata; expShared = 1'b0; chkData = 1'b1;
      @(posedge clk); #1;
      expGrant = '0; expRsp = 1'b0; chkData = 1'b0;
      return;
    end
    expSnoop = 1'b1; expKind = kind; expAddr = addr; expSrc = 2'(src);
    late = -1;
    if (stagger) for (int i = 0; i < N; i++) if (others[i] && late < 0) late = i;
    for (int i = 0; i < N; i++) begin
      if (others[i] && i != late) begin
        snpDone[i] = 1'b1; snpShared[i] = shM[i]; snpFlush[i] = flM[i];
        snpDirty[i] = dyM[i]; snpData[i] = flM[i] ? flushVal(i, addr) : '0;
      end
    end
    // requester's own junk answer must be ignored (R3)
    snpDone[src] = 1'b1; snpShared[src] = 1'b1; snpFlush[src] = 1'b1;
    snpDirty[src] = 1'b1; snpData[src] = 32'hBAD0BAD0;
    if (late >= 0) begin
      @(posedge clk); #1;
      clearAns();
      snpDone[late] = 1'b1; snpShared[late] = shM[late]; snpFlush[late] = flM[late];
      snpDirty[late] = dyM[late]; snpData[late] = flM[late] ? flushVal(late, addr) : '0;
    end
    @(posedge clk); #1;
    clearAns();
    expSnoop = 1'b0;
    fl = flM & others;
    expShared = |(shM & others);
    if (kind == 2'd2) begin
      expRsp = 1'b1; chkData = 1'b0;
    end else if (fl != 0) begin
      sel = -1;
      for (int i = 0; i < N; i++) if (fl[i] && sel < 0) sel = i;
      expData = flushVal(sel, addr);
      if ((dyM & fl) != 0) modelMem[addr[3:0]] = expData;
      expRsp = 1'b1; chkData = 1'b1;
    end else begin
      repeat (RD_LAT) begin @(posedge clk); #1; end
      expData = modelMem[addr[3:0]];
      expRsp = 1'b1; chkData = 1'b1;
    end
    @(posedge clk); #1;
    expGrant = '0; expRsp = 1'b0; chkData = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    finishRun();
  end

  initial begin
    for (int m = 0; m < 16; m++) modelMem[m] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    curTag = "R10"; // memory reads zero after reset, from memory with latency
    runTxn(0, 2'd0, 8'h05, '0, 4'b0000, 4'b0000, 4'b0000, 0);

    curTag = "R9";  // writeback stores line, then a snooped read sees it
    runTxn(2, 2'd3, 8'h05, 32'h1234ABCD, 4'b0, 4'b0, 4'b0, 0);
    curTag = "R6";
    runTxn(1, 2'd0, 8'h15, '0, 4'b0000, 4'b0000, 4'b0000, 0);

    curTag = "R4";  // two sharers, no flush
    runTxn(1, 2'd0, 8'h09, '0, 4'b1001, 4'b0000, 4'b0000, 0);

    curTag = "R7";  // dirty flush on read-for-ownership, late non-flusher
    runTxn(3, 2'd1, 8'h07, '0, 4'b0000, 4'b0100, 4'b0100, 1);
    runTxn(0, 2'd0, 8'h07, '0, 4'b0000, 4'b0000, 4'b0000, 0);

    curTag = "R5";  // late lower-index flusher displaces early one, both dirty
    runTxn(0, 2'd0, 8'h0C, '0, 4'b1010, 4'b1010, 4'b1010, 1);
    curTag = "R7";
    runTxn(2, 2'd0, 8'h0C, '0, 4'b0000, 4'b0000, 4'b0000, 0);

    curTag = "R5";  // clean flush from two caches: lowest wins, memory untouched
    runTxn(0, 2'd0, 8'h03, '0, 4'b1100, 4'b1100, 4'b0000, 0);
    curTag = "R7";
    runTxn(1, 2'd0, 8'h03, '0, 4'b0000, 4'b0000, 4'b0000, 0);

    curTag = "R8";  // upgrade: ack only, memory unchanged afterwards
    runTxn(2, 2'd2, 8'h09, '0, 4'b0010, 4'b0000, 4'b0000, 1);
    runTxn(3, 2'd0, 8'h09, '0, 4'b0000, 4'b0000, 4'b0000, 0);

    curTag = "R1";  // contention: cache 3 waits while cache 1 is served
    reqValid[3] = 1'b1; reqKind[3] = 2'd1; reqAddr[3] = 8'h0A;
    runTxn(1, 2'd0, 8'h05, '0, 4'b0000, 4'b0000, 4'b0000, 0);
    runTxn(3, 2'd1, 8'h0A, '0, 4'b0001, 4'b0001, 4'b0000, 0);

    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule